// File: doc/BRIEF.md
# Raster Scan Timing Generator

This block produces the timing skeleton of a raster display. It has a horizontal pixel counter and a vertical line counter. From them it derives an active-area flag, a gated video-enable, horizontal and vertical sync pins, a composite sync for sync-on-video, and a one-pixel prefetch strobe that fires at a programmable point in each line. The strobe warns the pixel fetch logic ahead of the next line.

All geometry comes from a small register set that is loaded through a simple write port. Each boundary is stored as a count minus one. A line of T pixels is therefore written as T-1, and a sync pulse of W pixels that follows A active pixels and F front-porch pixels is written as start A+F-1 and end A+F+W-1. Software clears the run bit while it reprograms the timing. After reset the registers hold a 1280x1024 mode, so only the run bit has to be set to start it. A sync control register and a display control register implement display power management: separate suspend of either sync, full sync powerdown, sync polarity, and blanking of the picture while the syncs keep running.

Top module: `vtg_top`

## Requirements
- R1: After reset the run bit (bit 0 of register 0) is clear. Both counters read 0 and active, video_on, prefetch and csync are low. hsync and vsync are low, because the polarity bits reset to 0.
- R2: While running, h_count steps by one per clock from 0 up to the value in register 1 (line total minus 1), then returns to 0.
- R3: v_count advances by one in the cycle that h_count wraps. After the value in register 5 (frame total minus 1) it returns to 0.
- R4: active is high exactly when running, h_count <= register 2 and v_count <= register 6.
- R5: The raw horizontal sync is asserted when register 3 < h_count <= register 4. The raw vertical sync is asserted when register 7 < v_count <= register 8, for whole lines. With the inversion bits clear, the pins equal the raw syncs.
- R6: In register 10, bit 3 inverts hsync and bit 4 inverts vsync, which makes that pin active-low.
- R7: In register 10, bit 5 holds hsync at its inactive level and bit 6 holds vsync at its inactive level. Bit 1 holds both at their inactive levels. The counters keep running in all three cases.
- R8: video_on equals active AND bit 1 of register 0 (refresh) AND NOT bit 1 of register 11 (display off).
- R9: csync is high when bit 0 of register 10 is set, bit 1 of register 10 is clear, and either raw sync is asserted. It ignores the polarity bits and the single-sync off bits.
- R10: prefetch is high for the single clock in which the generator is running and h_count equals register 9. This includes the last pixel of a line and pixels inside the sync pulse.
- R11: Clearing the run bit drives active, prefetch and the raw syncs inactive from the next cycle. Both counters read 0 one cycle later and stay there.
- R12: A write to any register takes effect in the cycle after the write edge. The reset values are register 1 = 1687, 2 = 1279, 3 = 1327, 4 = 1439, 5 = 1065, 6 = 1023, 7 = 1024, 8 = 1027 and 9 = 1332.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | 32 | Write data |
| h_count | output | CW | Horizontal pixel counter |
| v_count | output | CW | Vertical line counter |
| active | output | 1 | Inside the active window |
| video_on | output | 1 | Active and refresh on and display not off |
| hsync | output | 1 | Horizontal sync pin after polarity and off control |
| vsync | output | 1 | Vertical sync pin after polarity and off control |
| csync | output | 1 | Composite sync for sync-on-video |
| prefetch | output | 1 | One-pixel line prefetch strobe |

## Verification
The prefetch strobe and the horizontal sync are independent functions of the same counter, so they can fall in the same cycle. The bench provokes this by placing the prefetch position inside the sync window. It then places the prefetch position on the last pixel of the line, where the strobe coincides with the counter wrap and the vertical step. In every cycle of these frames the bench compares all outputs against its own counter model, so a strobe lost or doubled at the wrap, or a sync suppressed by the strobe, shows up in the exact cycle.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

   localparam int REG_AW  = 4;
   localparam int NUM_TIM = 9;

   // register indices
   localparam logic [REG_AW-1:0] A_CTRL = 4'd0;
   localparam logic [REG_AW-1:0] A_SYNC = 4'd10;
   localparam logic [REG_AW-1:0] A_DISP = 4'd11;
   // timing registers occupy indices 1..NUM_TIM in this order
   localparam int T_HTOT = 0;
   localparam int T_HACT = 1;
   localparam int T_HSS  = 2;
   localparam int T_HSE  = 3;
   localparam int T_VTOT = 4;
   localparam int T_VACT = 5;
   localparam int T_VSS  = 6;
   localparam int T_VSE  = 7;
   localparam int T_PF   = 8;

   // control bits
   localparam int B_RUN     = 0;
   localparam int B_REFRESH = 1;
   // sync control bits
   localparam int B_SOG     = 0;
   localparam int B_ALLOFF  = 1;
   localparam int B_HINV    = 3;
   localparam int B_VINV    = 4;
   localparam int B_HOFF    = 5;
   localparam int B_VOFF    = 6;
   // display control bit
   localparam int B_BLANK   = 1;

   // reset mode: 1280x1024, h porches 48/112/248, v porches 1/3/38
   function automatic int unsigned tim_default(int idx);
      case (idx)
         T_HTOT:  return 1687;
         T_HACT:  return 1279;
         T_HSS:   return 1327;
         T_HSE:   return 1439;
         T_VTOT:  return 1065;
         T_VACT:  return 1023;
         T_VSS:   return 1024;
         T_VSE:   return 1027;
         default: return 1332;
      endcase
   endfunction

endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
   import vtg_pkg::*;
#(
   parameter int CW = 12,
   parameter int DW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [DW-1:0]     wr_data,
   output logic [CW-1:0]     tim [NUM_TIM],
   output logic              run,
   output logic              refresh,
   output logic              sog,
   output logic              all_off,
   output logic              h_inv,
   output logic              v_inv,
   output logic              h_off,
   output logic              v_off,
   output logic              blank
);

   localparam int SYNC_BITS = 7;

   logic [1:0]           ctrl_q;
   logic [SYNC_BITS-1:0] sync_q;
   logic                 disp_q;

   for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim
      localparam logic [REG_AW-1:0] MY_ADDR = REG_AW'(g + 1);
      always_ff @(posedge clk) begin
         if (!rst_n)
            tim[g] <= CW'(tim_default(g));
         else if (wr_en && wr_addr == MY_ADDR)
            tim[g] <= wr_data[CW-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         sync_q <= '0;
         disp_q <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == A_CTRL) ctrl_q <= wr_data[1:0];
         if (wr_addr == A_SYNC) sync_q <= wr_data[SYNC_BITS-1:0];
         if (wr_addr == A_DISP) disp_q <= wr_data[B_BLANK];
      end
   end

   assign run     = ctrl_q[B_RUN];
   assign refresh = ctrl_q[B_REFRESH];
   assign sog     = sync_q[B_SOG];
   assign all_off = sync_q[B_ALLOFF];
   assign h_inv   = sync_q[B_HINV];
   assign v_inv   = sync_q[B_VINV];
   assign h_off   = sync_q[B_HOFF];
   assign v_off   = sync_q[B_VOFF];
   assign blank   = disp_q;

endmodule

// File: rtl/vtg_counters.sv
module vtg_counters #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [CW-1:0] h_last,
   input  logic [CW-1:0] v_last,
   output logic [CW-1:0] hcnt,
   output logic [CW-1:0] vcnt
);

   logic h_wrap, v_wrap;

   // >= so that shrinking the totals while running cannot strand a counter
   assign h_wrap = (hcnt >= h_last);
   assign v_wrap = (vcnt >= v_last);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         hcnt <= '0;
         vcnt <= '0;
      end else if (h_wrap) begin
         hcnt <= '0;
         vcnt <= v_wrap ? '0 : vcnt + 1'b1;
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end

   a_r2_h_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && hcnt < h_last) |=> hcnt == $past(hcnt) + 1'b1);
   a_r2_h_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (run && hcnt == h_last) |=> hcnt == '0);
   a_r3_v_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && hcnt == h_last && vcnt < v_last) |=> vcnt == $past(vcnt) + 1'b1);
   a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (hcnt == '0 && vcnt == '0));

endmodule

// File: rtl/vtg_syncs.sv
module vtg_syncs #(
   parameter int CW      = 12,
   parameter bit OUT_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [CW-1:0] hcnt,
   input  logic [CW-1:0] vcnt,
   input  logic [CW-1:0] h_act,
   input  logic [CW-1:0] v_act,
   input  logic [CW-1:0] h_ss,
   input  logic [CW-1:0] h_se,
   input  logic [CW-1:0] v_ss,
   input  logic [CW-1:0] v_se,
   input  logic [CW-1:0] pf_pos,
   input  logic          refresh,
   input  logic          blank,
   input  logic          sog,
   input  logic          all_off,
   input  logic          h_inv,
   input  logic          v_inv,
   input  logic          h_off,
   input  logic          v_off,
   output logic          active,
   output logic          video_on,
   output logic          hsync,
   output logic          vsync,
   output logic          csync,
   output logic          prefetch
);

   logic h_raw, v_raw, act_c, von_c, hs_c, vs_c, cs_c, pf_c;

   assign h_raw = run && (hcnt > h_ss) && (hcnt <= h_se);
   assign v_raw = run && (vcnt > v_ss) && (vcnt <= v_se);
   assign act_c = run && (hcnt <= h_act) && (vcnt <= v_act);
   assign von_c = act_c && refresh && !blank;
   assign hs_c  = (all_off || h_off) ? h_inv : (h_raw ^ h_inv);
   assign vs_c  = (all_off || v_off) ? v_inv : (v_raw ^ v_inv);
   assign cs_c  = sog && !all_off && (h_raw || v_raw);
   assign pf_c  = run && (hcnt == pf_pos);

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            {active, video_on, hsync, vsync, csync, prefetch} <= '0;
         end else begin
            active   <= act_c;
            video_on <= von_c;
            hsync    <= hs_c;
            vsync    <= vs_c;
            csync    <= cs_c;
            prefetch <= pf_c;
         end
      end
   end else begin : g_comb
      assign active   = act_c;
      assign video_on = von_c;
      assign hsync    = hs_c;
      assign vsync    = vs_c;
      assign csync    = cs_c;
      assign prefetch = pf_c;
   end

   a_r7_all_off: assert property (@(posedge clk) disable iff (!rst_n)
      all_off |-> (hs_c == h_inv && vs_c == v_inv && !cs_c));
   a_r11_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (!act_c && !pf_c && !h_raw && !v_raw));
   a_r8_video_in_active: assert property (@(posedge clk) disable iff (!rst_n)
      von_c |-> (act_c && hcnt <= h_act));

endmodule

// File: rtl/vtg_top.sv
module vtg_top
   import vtg_pkg::*;
#(
   parameter int CW      = 12,
   parameter int DW      = 32,
   parameter bit OUT_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [3:0]    wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic [CW-1:0] h_count,
   output logic [CW-1:0] v_count,
   output logic          active,
   output logic          video_on,
   output logic          hsync,
   output logic          vsync,
   output logic          csync,
   output logic          prefetch
);

   if (CW < 11 || CW > DW) begin : g_bad_cw
      $error("vtg_top: CW must hold the reset mode and fit in DW");
   end
   if (DW < 8) begin : g_bad_dw
      $error("vtg_top: DW must cover the control bits");
   end

   logic [CW-1:0] tim [NUM_TIM];
   logic run, refresh, sog, all_off, h_inv, v_inv, h_off, v_off, blank;

   vtg_regs #(.CW(CW), .DW(DW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .tim     (tim),
      .run     (run),
      .refresh (refresh),
      .sog     (sog),
      .all_off (all_off),
      .h_inv   (h_inv),
      .v_inv   (v_inv),
      .h_off   (h_off),
      .v_off   (v_off),
      .blank   (blank)
   );

   vtg_counters #(.CW(CW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .h_last (tim[T_HTOT]),
      .v_last (tim[T_VTOT]),
      .hcnt   (h_count),
      .vcnt   (v_count)
   );

   vtg_syncs #(.CW(CW), .OUT_REG(OUT_REG)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .hcnt     (h_count),
      .vcnt     (v_count),
      .h_act    (tim[T_HACT]),
      .v_act    (tim[T_VACT]),
      .h_ss     (tim[T_HSS]),
      .h_se     (tim[T_HSE]),
      .v_ss     (tim[T_VSS]),
      .v_se     (tim[T_VSE]),
      .pf_pos   (tim[T_PF]),
      .refresh  (refresh),
      .blank    (blank),
      .sog      (sog),
      .all_off  (all_off),
      .h_inv    (h_inv),
      .v_inv    (v_inv),
      .h_off    (h_off),
      .v_off    (v_off),
      .active   (active),
      .video_on (video_on),
      .hsync    (hsync),
      .vsync    (vsync),
      .csync    (csync),
      .prefetch (prefetch)
   );

endmodule

// File: tb/vtg_top_tb.sv
module vtg_top_tb;

   localparam int CW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [3:0]    wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [CW-1:0] h_count, v_count;
   logic          active, video_on, hsync, vsync, csync, prefetch;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   // bench-side copy of programmed state
   int m_tim [9];
   int m_run, m_ref, m_sync, m_disp;
   int mh, mv;

   always #10 clk = ~clk;

   vtg_top #(.CW(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .h_count(h_count), .v_count(v_count),
      .active(active), .video_on(video_on), .hsync(hsync), .vsync(vsync),
      .csync(csync), .prefetch(prefetch)
   );

   task automatic model_defaults();
      m_tim = '{1687, 1279, 1327, 1439, 1065, 1023, 1024, 1027, 1332};
      m_run = 0; m_ref = 0; m_sync = 0; m_disp = 0; mh = 0; mv = 0;
   endtask

   task automatic model_step();
      if (m_run == 0) begin
         mh = 0; mv = 0;
      end else if (mh >= m_tim[0]) begin
         mh = 0;
         mv = (mv >= m_tim[4]) ? 0 : mv + 1;
      end else begin
         mh = mh + 1;
      end
   endtask

   // called at a negedge; returns at the next negedge
   task automatic wr(input int addr, input int data);
      wr_en = 1'b1; wr_addr = 4'(addr); wr_data = data;
      @(posedge clk);
      model_step();
      if (addr == 0) begin m_run = data & 1; m_ref = (data >> 1) & 1; end
      else if (addr >= 1 && addr <= 9) m_tim[addr-1] = data;
      else if (addr == 10) m_sync = data & 8'h7b;
      else if (addr == 11) m_disp = (data >> 1) & 1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic check_now(input string tag);
      bit hr, vr, ac, hs, vs, vo, cs, pf, allo;
      bit [CW-1:0] eh, ev;
      eh = CW'(mh); ev = CW'(mv);
      hr = m_run != 0 && mh > m_tim[2] && mh <= m_tim[3];
      vr = m_run != 0 && mv > m_tim[6] && mv <= m_tim[7];
      ac = m_run != 0 && mh <= m_tim[1] && mv <= m_tim[5];
      allo = m_sync[1];
      hs = (allo || m_sync[5]) ? m_sync[3] : (hr ^ m_sync[3]);
      vs = (allo || m_sync[6]) ? m_sync[4] : (vr ^ m_sync[4]);
      vo = ac && m_ref != 0 && m_disp == 0;
      cs = m_sync[0] && !allo && (hr || vr);
      pf = m_run != 0 && mh == m_tim[8];
      tests++;
      if (h_count !== eh || v_count !== ev || active !== ac || hsync !== hs ||
          vsync !== vs || video_on !== vo || csync !== cs || prefetch !== pf) begin
         fails++;
         $display("FAIL %s h=%0d/%0d v=%0d/%0d act=%b/%b hs=%b/%b vs=%b/%b von=%b/%b cs=%b/%b pf=%b/%b (actual/expected)",
                  tag, h_count, eh, v_count, ev, active, ac, hsync, hs, vsync, vs,
                  video_on, vo, csync, cs, prefetch, pf);
      end
   endtask

   task automatic run_cycles(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         check_now(tag);
         @(posedge clk);
         model_step();
         @(negedge clk);
      end
   endtask

   // 8x4 active, h porches 2/3/3 (total 16), v porches 1/2/1 (total 8)
   task automatic load_small(input int pf);
      wr(0, 0);
      wr(1, 15); wr(2, 7); wr(3, 9); wr(4, 12);
      wr(5, 7);  wr(6, 3); wr(7, 4); wr(8, 6);
      wr(9, pf);
   endtask

   task automatic t_reset();
      check_now("R1 reset state");
   endtask

   task automatic t_defaults();
      // R12: reset mode visible once running; covers one full line wrap
      wr(0, 3);
      run_cycles(1700, "R12 R2 R4 R5 R10 default mode");
   endtask

   task automatic t_frame();
      load_small(13);
      wr(0, 3);
      run_cycles(2 * 128 + 5, "R2 R3 R4 R5 R8 small frames");
   endtask

   task automatic t_polarity();
      wr(10, 8'h18);
      run_cycles(130, "R6 inverted syncs");
   endtask

   task automatic t_suspend();
      wr(10, 8'h20);
      run_cycles(130, "R7 hsync off");
      wr(10, 8'h40);
      run_cycles(130, "R7 vsync off");
      wr(10, 8'h1a);
      run_cycles(130, "R7 all off inverted");
      wr(10, 0);
   endtask

   task automatic t_blank();
      wr(11, 2);
      run_cycles(40, "R8 display off");
      wr(11, 0);
      wr(0, 1);
      run_cycles(40, "R8 refresh clear");
      wr(0, 3);
   endtask

   task automatic t_composite();
      wr(10, 8'h39);
      run_cycles(130, "R9 sync on video");
      wr(10, 8'h03);
      run_cycles(40, "R9 all off kills csync");
      wr(10, 0);
   endtask

   task automatic t_prefetch_overlap();
      wr(9, 10);
      run_cycles(130, "R10 prefetch inside hsync");
      wr(9, 15);
      run_cycles(130, "R10 prefetch at line wrap");
   endtask

   task automatic t_disable();
      run_cycles(5, "R11 before stop");
      wr(0, 0);
      // outputs idle right away, counters clear one cycle later
      tests++;
      if (active !== 1'b0 || prefetch !== 1'b0 || hsync !== 1'b0) begin
         fails++;
         $display("FAIL R11 idle outputs act=%b pf=%b hs=%b expected 0", active, prefetch, hsync);
      end
      @(posedge clk); model_step(); @(negedge clk);
      tests++;
      if (h_count !== '0 || v_count !== '0) begin
         fails++;
         $display("FAIL R11 counters h=%0d v=%0d expected 0/0", h_count, v_count);
      end
      run_cycles(20, "R11 held idle");
   endtask

   initial begin
      model_defaults();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_defaults();
      t_frame();
      t_polarity();
      t_suspend();
      t_blank();
      t_composite();
      t_prefetch_overlap();
      t_disable();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule